// File: doc/BRIEF.md
# Memory-Type Access Policy Controller

This block sits between a load/store pipeline and a level-one data cache. For each access it receives the operation, address, size, store data, resolved memory type and a speculation flag. It then decides how the access is carried out. It may be served from the cache, filled into the cache from the bus, sent to the bus with any stale cached copy evicted, written through to the bus while a hit line is updated, or handed to a write-combining path. The cache arrays, the bus and the write-combining storage are outside the block. It drives them through single-cycle request strobes and waits for their completion strobes.

The controller always consults the cache, even for uncacheable types, so that a stale copy is never left behind. It keeps one access in flight at a time and back-pressures the pipeline with a ready signal. An uncacheable load that is still speculative is parked until the pipeline releases it. Cacheable loads that miss fetch a whole line, and the addressed word is returned once the fill is installed.

Top module: `mtype_policy_ctrl`

## Requirements
- R1: Every accepted access issues exactly one cache lookup (`cl_op` 0 read, 1 evict-on-hit, 2 write-through update, 3 write-back update) before any bus or write-combining output appears, whatever its memory type. Memory types on `req_mtype` are 0 UC, 1 WC, 2 WT, 3 WP, 4 WB.
- R2: A load of type WT, WP or WB that hits (lookup op 0) responds with the cache data and makes no bus request.
- R3: A load of type WT, WP or WB that misses issues one bus read with `bus_size` equal to log2 of the line size (6 for 64 bytes). On completion it issues an install op (`cl_op` 4) and then responds with the bus data.
- R4: A UC or WC load uses lookup op 1, which evicts on a hit. Hit or miss, it issues one bus read of exactly the request's `req_size` and never installs a line.
- R5: A UC store uses lookup op 1 and then issues one bus write with the request's address, size and data. It never installs a line.
- R6: A WT store uses lookup op 2, which updates a hit line and leaves it shared. It always issues one bus write. On a miss it never installs a line (no `cl_op` 4 or 5).
- R7: A UC load with `req_spec` set makes no cache or bus request until `spec_resolve` is pulsed. After that it proceeds as in R4.
- R8: A speculative load of type WC, WT, WP or WB proceeds at once without waiting for `spec_resolve`.
- R9: A WC store uses lookup op 1 and then presents the store on `wc_valid` with address, size and data. Those values are held stable until `wc_ready`, and no bus request is made.
- R10: A WB store uses lookup op 3. On a hit it responds with no bus request. On a miss it issues a line read, then an install-with-merge op (`cl_op` 5).
- R11: `req_ready` is high only when no access is in flight. It drops the cycle after acceptance and returns after `rsp_valid`. At most one of `cl_req`, `bus_req`, `wc_valid`, `rsp_valid` is high in any cycle.
- R12: A WP store and any access with an undefined type code (5 to 7) follow the UC behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Pipeline access valid |
| req_ready | output | 1 | Controller idle, access accepted when valid |
| req_store | input | 1 | 1 store, 0 load |
| req_addr | input | ADDR_W | Physical byte address |
| req_size | input | 3 | log2 of access bytes |
| req_wdata | input | DATA_W | Store data |
| req_mtype | input | 3 | Resolved memory type |
| req_spec | input | 1 | Access is still speculative |
| spec_resolve | input | 1 | Pulse: parked access is now non-speculative |
| cl_req | output | 1 | Cache operation strobe |
| cl_op | output | 3 | Cache operation code |
| cl_addr | output | ADDR_W | Cache operation address |
| cl_size | output | 3 | Cache operation log2 size |
| cl_wdata | output | DATA_W | Cache write data |
| cl_rsp | input | 1 | Lookup completion strobe |
| cl_hit | input | 1 | Lookup hit, valid with cl_rsp |
| cl_rdata | input | DATA_W | Lookup read word, valid with cl_rsp |
| bus_req | output | 1 | Bus request strobe |
| bus_we | output | 1 | Bus write |
| bus_addr | output | ADDR_W | Bus address |
| bus_size | output | 3 | log2 of bytes transferred |
| bus_wdata | output | DATA_W | Bus write data |
| bus_done | input | 1 | Bus completion strobe |
| bus_rdata | input | DATA_W | Word at the request address, valid with bus_done |
| wc_valid | output | 1 | Store offered to write-combining path |
| wc_addr | output | ADDR_W | Write-combining address |
| wc_size | output | 3 | Write-combining log2 size |
| wc_data | output | DATA_W | Write-combining data |
| wc_ready | input | 1 | Write-combining path accepts |
| rsp_valid | output | 1 | Access complete |
| rsp_rdata | output | DATA_W | Load result |

## Verification
A wrong policy decision is visible within a cycle of the lookup completing. The next strobe is then a bus request where a response was due, a line-sized read for an uncacheable type, or an install op after a write-through miss. A stuck or mis-set hold state shows as a lookup strobe appearing before the release pulse, or as no strobe at all once the release arrives. A sequencer that loses its place shows as `req_ready` rising early, or as two strobes overlapping in one cycle.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

   localparam logic [2:0] MT_UC = 3'd0;
   localparam logic [2:0] MT_WC = 3'd1;
   localparam logic [2:0] MT_WT = 3'd2;
   localparam logic [2:0] MT_WP = 3'd3;
   localparam logic [2:0] MT_WB = 3'd4;

   typedef enum logic [2:0] {
      COP_READ   = 3'd0,
      COP_EVICT  = 3'd1,
      COP_WRTHRU = 3'd2,
      COP_WRBACK = 3'd3,
      COP_ALLOC  = 3'd4,
      COP_ALLOCW = 3'd5
   } cop_e;

   typedef enum logic [2:0] {
      ACT_DONE,
      ACT_FILL,
      ACT_BUSRD,
      ACT_BUSWR,
      ACT_WC
   } act_e;

   typedef enum logic [3:0] {
      S_IDLE, S_CLOOK, S_CWAIT, S_HOLD, S_BUS, S_BWAIT, S_ALLOC, S_WC, S_RESP
   } st_e;

   function automatic logic is_cacheable(input logic [2:0] t);
      return (t == MT_WT) || (t == MT_WP) || (t == MT_WB);
   endfunction

endpackage

// File: rtl/mtp_policy.sv
module mtp_policy
   import mtp_pkg::*;
(
   input  logic       is_store,
   input  logic [2:0] mtype,
   input  logic       spec,
   input  logic       hit,
   output cop_e       look_op,
   output act_e       act,
   output logic       hold_req,
   output logic       cacheable
);

   logic is_wc;

   always_comb begin
      cacheable = is_cacheable(mtype);
      is_wc     = (mtype == MT_WC);
      hold_req  = !is_store && spec && !cacheable && !is_wc;

      if (!is_store)
         look_op = cacheable ? COP_READ : COP_EVICT;
      else if (mtype == MT_WB)
         look_op = COP_WRBACK;
      else if (mtype == MT_WT)
         look_op = COP_WRTHRU;
      else
         look_op = COP_EVICT;

      if (!is_store)
         act = !cacheable ? ACT_BUSRD : (hit ? ACT_DONE : ACT_FILL);
      else if (mtype == MT_WB)
         act = hit ? ACT_DONE : ACT_FILL;
      else if (is_wc)
         act = ACT_WC;
      else
         act = ACT_BUSWR;
   end

endmodule

// File: rtl/mtp_seq.sv
module mtp_seq
   import mtp_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 64,
   parameter int LINE_LOG2 = 6,
   parameter int SIZE_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_store,
   input  logic [AW-1:0]     req_addr,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [DW-1:0]     req_wdata,
   input  logic [2:0]        req_mtype,
   input  logic              req_spec,
   input  logic              spec_resolve,
   output logic              lat_store,
   output logic [2:0]        lat_mtype,
   output logic              lat_spec,
   input  cop_e              look_op,
   input  act_e              act,
   input  logic              hold_req,
   input  logic              cacheable,
   output logic              cl_req,
   output logic [2:0]        cl_op,
   output logic [AW-1:0]     cl_addr,
   output logic [SIZE_W-1:0] cl_size,
   output logic [DW-1:0]     cl_wdata,
   input  logic              cl_rsp,
   input  logic [DW-1:0]     cl_rdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic [AW-1:0]     bus_addr,
   output logic [SIZE_W-1:0] bus_size,
   output logic [DW-1:0]     bus_wdata,
   input  logic              bus_done,
   input  logic [DW-1:0]     bus_rdata,
   output logic              wc_valid,
   output logic [AW-1:0]     wc_addr,
   output logic [SIZE_W-1:0] wc_size,
   output logic [DW-1:0]     wc_data,
   input  logic              wc_ready,
   output logic              rsp_valid,
   output logic [DW-1:0]     rsp_rdata
);

   localparam logic [SIZE_W-1:0] LINE_SZ = SIZE_W'(LINE_LOG2);

   st_e               st, st_nx;
   act_e              act_q;
   logic              released;
   logic              parked;
   logic [AW-1:0]     addr_q;
   logic [SIZE_W-1:0] size_q;
   logic [DW-1:0]     wdata_q;
   logic [DW-1:0]     data_q;

   assign parked = hold_req && !released;

   always_comb begin
      st_nx = st;
      case (st)
         S_IDLE:  if (req_valid) st_nx = S_CLOOK;
         S_CLOOK: st_nx = parked ? S_HOLD : S_CWAIT;
         S_HOLD:  if (spec_resolve) st_nx = S_CLOOK;
         S_CWAIT:
            if (cl_rsp) begin
               case (act)
                  ACT_DONE: st_nx = S_RESP;
                  ACT_WC:   st_nx = S_WC;
                  default:  st_nx = S_BUS;
               endcase
            end
         S_BUS:   st_nx = S_BWAIT;
         S_BWAIT: if (bus_done) st_nx = (act_q == ACT_FILL) ? S_ALLOC : S_RESP;
         S_ALLOC: st_nx = S_RESP;
         S_WC:    if (wc_ready) st_nx = S_RESP;
         S_RESP:  st_nx = S_IDLE;
         default: st_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         act_q     <= ACT_DONE;
         released  <= 1'b0;
         lat_store <= 1'b0;
         lat_mtype <= MT_UC;
         lat_spec  <= 1'b0;
         addr_q    <= '0;
         size_q    <= '0;
         wdata_q   <= '0;
         data_q    <= '0;
      end else begin
         st <= st_nx;
         if (st == S_IDLE && req_valid) begin
            lat_store <= req_store;
            lat_mtype <= req_mtype;
            lat_spec  <= req_spec;
            addr_q    <= req_addr;
            size_q    <= req_size;
            wdata_q   <= req_wdata;
            released  <= 1'b0;
         end
         if (st == S_HOLD && spec_resolve) released <= 1'b1;
         if (st == S_CWAIT && cl_rsp) begin
            act_q  <= act;
            data_q <= cl_rdata;
         end
         if (st == S_BWAIT && bus_done && !lat_store) data_q <= bus_rdata;
      end
   end

   assign req_ready = (st == S_IDLE);
   assign cl_req    = ((st == S_CLOOK) && !parked) || (st == S_ALLOC);
   assign cl_op     = (st == S_ALLOC) ? (lat_store ? COP_ALLOCW : COP_ALLOC) : look_op;
   assign cl_addr   = addr_q;
   assign cl_size   = size_q;
   assign cl_wdata  = wdata_q;
   assign bus_req   = (st == S_BUS);
   assign bus_we    = (act_q == ACT_BUSWR);
   assign bus_addr  = addr_q;
   assign bus_size  = (act_q == ACT_FILL) ? LINE_SZ : size_q;
   assign bus_wdata = wdata_q;
   assign wc_valid  = (st == S_WC);
   assign wc_addr   = addr_q;
   assign wc_size   = size_q;
   assign wc_data   = wdata_q;
   assign rsp_valid = (st == S_RESP);
   assign rsp_rdata = data_q;

   assert_ready_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready)
      else $error("ready stayed high after acceptance");

   assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cl_req, bus_req, wc_valid, rsp_valid}))
      else $error("overlapping strobes");

   assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_HOLD) |-> !cl_req && !bus_req && !wc_valid)
      else $error("activity while parked");

   assert_alloc_cacheable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cl_req && (cl_op == COP_ALLOC || cl_op == COP_ALLOCW) |-> cacheable)
      else $error("install for uncacheable type");

   assert_uc_exact_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !cacheable |-> bus_size == size_q)
      else $error("uncacheable bus access not sized to request");

   assert_wc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wc_valid && !wc_ready |=> wc_valid && $stable(wc_data) && $stable(wc_addr))
      else $error("write-combining offer dropped or changed");

endmodule

// File: rtl/mtype_policy_ctrl.sv
module mtype_policy_ctrl
   import mtp_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter int LINE_BYTES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_store,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [2:0]        req_mtype,
   input  logic              req_spec,
   input  logic              spec_resolve,
   output logic              cl_req,
   output logic [2:0]        cl_op,
   output logic [ADDR_W-1:0] cl_addr,
   output logic [2:0]        cl_size,
   output logic [DATA_W-1:0] cl_wdata,
   input  logic              cl_rsp,
   input  logic              cl_hit,
   input  logic [DATA_W-1:0] cl_rdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [2:0]        bus_size,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_done,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              wc_valid,
   output logic [ADDR_W-1:0] wc_addr,
   output logic [2:0]        wc_size,
   output logic [DATA_W-1:0] wc_data,
   input  logic              wc_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);

   localparam int LINE_LOG2 = $clog2(LINE_BYTES);
   localparam int SIZE_W    = 3;

   initial begin
      assert (LINE_BYTES == (1 << LINE_LOG2))
         else $error("LINE_BYTES must be a power of two");
      assert (LINE_BYTES >= DATA_W / 8 && LINE_LOG2 < (1 << SIZE_W))
         else $error("line size out of range");
      assert (DATA_W >= 8 && DATA_W == (8 << $clog2(DATA_W / 8)))
         else $error("DATA_W must be a power-of-two byte count");
   end

   logic       lat_store, lat_spec, hold_req, cacheable;
   logic [2:0] lat_mtype;
   cop_e       look_op;
   act_e       act;

   mtp_policy u_policy (
      .is_store  (lat_store),
      .mtype     (lat_mtype),
      .spec      (lat_spec),
      .hit       (cl_hit),
      .look_op   (look_op),
      .act       (act),
      .hold_req  (hold_req),
      .cacheable (cacheable)
   );

   mtp_seq #(
      .AW(ADDR_W), .DW(DATA_W), .LINE_LOG2(LINE_LOG2), .SIZE_W(SIZE_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .req_mtype(req_mtype), .req_spec(req_spec), .spec_resolve(spec_resolve),
      .lat_store(lat_store), .lat_mtype(lat_mtype), .lat_spec(lat_spec),
      .look_op(look_op), .act(act), .hold_req(hold_req), .cacheable(cacheable),
      .cl_req(cl_req), .cl_op(cl_op), .cl_addr(cl_addr), .cl_size(cl_size),
      .cl_wdata(cl_wdata), .cl_rsp(cl_rsp), .cl_rdata(cl_rdata),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
      .wc_valid(wc_valid), .wc_addr(wc_addr), .wc_size(wc_size), .wc_data(wc_data),
      .wc_ready(wc_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

endmodule

// File: tb/mtype_policy_ctrl_tb.sv
module mtype_policy_ctrl_tb;

   localparam logic [63:0] CDATA = 64'hC0C1_C2C3_C4C5_C6C7;
   localparam logic [63:0] BDATA = 64'hB0B1_B2B3_B4B5_B6B7;

   logic        clk = 0, rst_n = 0;
   logic        req_valid = 0, req_store = 0, req_spec = 0, spec_resolve = 0;
   logic [31:0] req_addr = 0;
   logic [2:0]  req_size = 0, req_mtype = 0;
   logic [63:0] req_wdata = 0;
   logic        cl_rsp = 0, cl_hit = 0, bus_done = 0, wc_ready = 0;
   logic [63:0] cl_rdata = 0, bus_rdata = 0;
   logic        req_ready, cl_req, bus_req, bus_we, wc_valid, rsp_valid;
   logic [2:0]  cl_op, cl_size, bus_size, wc_size;
   logic [31:0] cl_addr, bus_addr, wc_addr;
   logic [63:0] cl_wdata, bus_wdata, wc_data, rsp_rdata;

   int n_run = 0, n_fail = 0;

   int          n_look, n_alloc, n_bus, wc_cyc;
   logic [2:0]  look_op_s, alloc_op_s, bus_size_s;
   logic        bus_we_s, bus_early, cl_early, rsp_seen, busy_ready, wc_change;
   logic [31:0] bus_addr_s;
   logic [63:0] bus_wdata_s, wc_data_s, rsp_data_s;

   always #2.5 clk = ~clk;

   mtype_policy_ctrl u_dut (.*);

   task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_access(input logic st, input logic [2:0] mt, input logic [31:0] a,
                             input logic [2:0] sz, input logic [63:0] wd, input logic spec,
                             input logic hit, input int hold_n);
      logic pend_cl, pend_bus, resolved;
      n_look = 0; n_alloc = 0; n_bus = 0; wc_cyc = 0;
      look_op_s = 3'h7; alloc_op_s = 3'h7; bus_size_s = 0; bus_we_s = 0;
      bus_early = 0; cl_early = 0; rsp_seen = 0; busy_ready = 0; wc_change = 0;
      bus_addr_s = 0; bus_wdata_s = 0; wc_data_s = 0; rsp_data_s = 0;
      pend_cl = 0; pend_bus = 0; resolved = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_store = st; req_mtype = mt; req_addr = a;
      req_size = sz; req_wdata = wd; req_spec = spec;
      for (int c = 0; c < 80 && !rsp_seen; c++) begin
         @(negedge clk);
         req_valid = 0;
         cl_rsp = 0; bus_done = 0; spec_resolve = 0; wc_ready = 0;
         if (pend_cl) begin cl_rsp = 1; cl_hit = hit; cl_rdata = CDATA; pend_cl = 0; end
         if (pend_bus) begin bus_done = 1; bus_rdata = BDATA; pend_bus = 0; end
         if (c == hold_n) begin spec_resolve = 1; resolved = 1; end
         if (req_ready) busy_ready = 1;
         if (cl_req) begin
            if (cl_op == 3'd4 || cl_op == 3'd5) begin
               n_alloc++; alloc_op_s = cl_op;
            end else begin
               n_look++; look_op_s = cl_op; pend_cl = 1;
               if (!resolved && hold_n < 80) cl_early = 1;
            end
         end
         if (bus_req) begin
            n_bus++; bus_we_s = bus_we; bus_size_s = bus_size;
            bus_addr_s = bus_addr; bus_wdata_s = bus_wdata; pend_bus = 1;
            if (n_look == 0) bus_early = 1;
         end
         if (wc_valid) begin
            if (wc_cyc > 0 && wc_data != wc_data_s) wc_change = 1;
            wc_cyc++; wc_data_s = wc_data;
            if (n_look == 0) bus_early = 1;
            if (wc_cyc == 3) wc_ready = 1;
         end
         if (rsp_valid) begin rsp_seen = 1; rsp_data_s = rsp_rdata; end
      end
      @(negedge clk);
      cl_rsp = 0; bus_done = 0; spec_resolve = 0; wc_ready = 0;
      chk(rsp_seen, "R11 access completes", 64'(rsp_seen), 1);
   endtask

   task automatic t_reset;
      chk(req_ready === 1'b1, "R11 ready after reset", 64'(req_ready), 1);
      chk({cl_req, bus_req, wc_valid, rsp_valid} === 4'b0, "R11 strobes idle after reset",
          64'({cl_req, bus_req, wc_valid, rsp_valid}), 0);
   endtask

   task automatic t_wb_load_hit;
      run_access(0, 3'd4, 32'h1000, 3, 0, 0, 1, 1000);
      chk(n_look == 1 && look_op_s == 0, "R1 R2 lookup read op", 64'(look_op_s), 0);
      chk(n_bus == 0, "R2 hit makes no bus request", 64'(n_bus), 0);
      chk(rsp_data_s == CDATA, "R2 cache data returned", rsp_data_s, CDATA);
      chk(!busy_ready, "R11 ready low while busy", 64'(busy_ready), 0);
      chk(req_ready === 1'b1, "R11 ready returns after response", 64'(req_ready), 1);
   endtask

   task automatic t_wt_load_miss;
      run_access(0, 3'd2, 32'h2008, 3, 0, 0, 0, 1000);
      chk(n_bus == 1 && !bus_we_s && bus_size_s == 6, "R3 line read size", 64'(bus_size_s), 6);
      chk(bus_addr_s == 32'h2008, "R3 fill address", 64'(bus_addr_s), 64'h2008);
      chk(n_alloc == 1 && alloc_op_s == 4, "R3 install op", 64'(alloc_op_s), 4);
      chk(rsp_data_s == BDATA, "R3 fill word returned", rsp_data_s, BDATA);
   endtask

   task automatic t_uc_load;
      run_access(0, 3'd0, 32'h3004, 2, 0, 0, 1, 1000);
      chk(look_op_s == 1, "R4 UC load evict lookup", 64'(look_op_s), 1);
      chk(n_bus == 1 && !bus_we_s && bus_size_s == 2, "R4 UC partial read", 64'(bus_size_s), 2);
      chk(n_alloc == 0, "R4 UC no install", 64'(n_alloc), 0);
      chk(rsp_data_s == BDATA, "R4 UC bus data", rsp_data_s, BDATA);
      run_access(0, 3'd1, 32'h3010, 1, 0, 1, 0, 1000);
      chk(look_op_s == 1 && n_bus == 1 && bus_size_s == 1 && n_alloc == 0,
          "R4 R8 speculative WC load partial read", 64'(bus_size_s), 1);
   endtask

   task automatic t_uc_store;
      run_access(1, 3'd0, 32'h4002, 1, 64'h1234, 0, 1, 1000);
      chk(look_op_s == 1 && !bus_early, "R1 R5 evict lookup first", 64'(look_op_s), 1);
      chk(n_bus == 1 && bus_we_s && bus_size_s == 1, "R5 single bus write", 64'(n_bus), 1);
      chk(bus_wdata_s == 64'h1234 && bus_addr_s == 32'h4002, "R5 write data", bus_wdata_s, 64'h1234);
      chk(n_alloc == 0, "R5 no install", 64'(n_alloc), 0);
   endtask

   task automatic t_wt_store;
      run_access(1, 3'd2, 32'h5000, 3, 64'h55, 0, 1, 1000);
      chk(look_op_s == 2 && n_bus == 1 && bus_we_s, "R6 WT hit update and write-through", 64'(look_op_s), 2);
      run_access(1, 3'd2, 32'h5040, 3, 64'h66, 0, 0, 1000);
      chk(n_bus == 1 && bus_we_s && bus_wdata_s == 64'h66, "R6 WT miss write-through", bus_wdata_s, 64'h66);
      chk(n_alloc == 0, "R6 WT miss no install", 64'(n_alloc), 0);
   endtask

   task automatic t_uc_spec;
      run_access(0, 3'd0, 32'h6000, 3, 0, 1, 0, 6);
      chk(!cl_early, "R7 no lookup before release", 64'(cl_early), 0);
      chk(n_look == 1 && look_op_s == 1 && n_bus == 1 && bus_size_s == 3,
          "R7 proceeds after release", 64'(n_bus), 1);
      run_access(0, 3'd3, 32'h6040, 3, 0, 1, 1, 1000);
      chk(n_look == 1 && rsp_data_s == CDATA, "R8 speculative WP load proceeds", rsp_data_s, CDATA);
   endtask

   task automatic t_wc_store;
      run_access(1, 3'd1, 32'h7003, 0, 64'hA5, 0, 1, 1000);
      chk(look_op_s == 1 && !bus_early, "R9 evict lookup before offer", 64'(look_op_s), 1);
      chk(n_bus == 0, "R9 no bus request", 64'(n_bus), 0);
      chk(wc_cyc == 3 && !wc_change, "R9 offer held until ready", 64'(wc_cyc), 3);
      chk(wc_data_s == 64'hA5, "R9 offer data", wc_data_s, 64'hA5);
   endtask

   task automatic t_wb_store;
      run_access(1, 3'd4, 32'h8000, 3, 64'h77, 0, 1, 1000);
      chk(look_op_s == 3 && n_bus == 0, "R10 WB hit no bus", 64'(n_bus), 0);
      run_access(1, 3'd4, 32'h8100, 3, 64'h88, 0, 0, 1000);
      chk(n_bus == 1 && !bus_we_s && bus_size_s == 6, "R10 WB miss line read", 64'(bus_size_s), 6);
      chk(n_alloc == 1 && alloc_op_s == 5, "R10 install with merge", 64'(alloc_op_s), 5);
   endtask

   task automatic t_uc_like;
      run_access(1, 3'd3, 32'h9000, 2, 64'h99, 0, 1, 1000);
      chk(look_op_s == 1 && n_bus == 1 && bus_we_s && n_alloc == 0, "R12 WP store as UC", 64'(look_op_s), 1);
      run_access(0, 3'd7, 32'h9100, 1, 0, 1, 1, 7);
      chk(!cl_early && look_op_s == 1 && bus_size_s == 1 && n_alloc == 0,
          "R12 undefined type held and partial", 64'(bus_size_s), 1);
   endtask

   initial begin
      for (int i = 0; i < 100000; i++) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_wb_load_hit();
      t_wt_load_miss();
      t_uc_load();
      t_uc_store();
      t_wt_store();
      t_uc_spec();
      t_wc_store();
      t_wb_store();
      t_uc_like();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule